// File: doc/BRIEF.md
# I/Q Proportional-Integral Field Regulator

This block keeps an RF field at a demanded operating point by running two proportional-integral loops side by side: one acts on the in-phase (I) component and the other on the quadrature (Q) component. Each sample marked valid carries a measured I/Q pair (for example a summed cavity probe signal), a target I/Q pair and a per-sample feed-forward I/Q correction. For each channel the block takes the target minus the measurement as the error. It scales that error by the proportional gain and adds it to a running integral scaled by the integral gain. The feed-forward value is added last, and the saturated result is registered as the drive towards a modulator.

The two gains, the integrator bound and the loop enable are ordinary inputs. They can change between any two samples, and a new value applies from the next valid sample on. There is no derivative path. With the loop disabled the integrators are held at zero and the output carries only the feed-forward term, so a filling ramp can be played through open-loop before regulation starts.

Top module: `iq_pi_ctrl`

## Requirements
- R1: Per channel, the error is target minus measurement, and the proportional term is round(kp × error / 4096), with a tie rounded towards plus infinity. The gain kp is unsigned 16-bit with 12 fractional bits.
- R2: On each valid sample with the loop enabled, the integrator adds round(ki × error / 4096), using the same gain format and rounding. The output of that sample already includes the updated integrator value.
- R3: After each update the integrator is clamped to the range [−integ_lim, +integ_lim], where integ_lim is an unsigned 16-bit value.
- R4: While loop_en is low the integrators are forced to zero on every clock. A valid sample then produces only the feed-forward term, and integration restarts from zero once the loop is enabled again.
- R5: The drive output is proportional term + integrator + feed-forward, saturated to the range −32768…32767.
- R6: sat_i / sat_q is high for exactly the one cycle in which out_valid presents a sample whose sum had to be saturated. It is low at all other times.
- R7: out_valid is in_valid delayed by one clock. drive_i and drive_q change only in the cycle after a valid input, and they hold their value otherwise.
- R8: The I and Q channels are independent: each output depends only on its own channel's inputs and integrator.
- R9: A change of kp, ki or integ_lim takes effect on the first valid sample presented with the new value.
- R10: After reset the outputs, the flags, out_valid and both integrators are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| loop_en | input | 1 | Closes the loop; low clears the integrators |
| in_valid | input | 1 | A new sample is present on the data inputs |
| meas_i | input | 16 | Measured I, signed |
| meas_q | input | 16 | Measured Q, signed |
| setp_i | input | 16 | Target I, signed |
| setp_q | input | 16 | Target Q, signed |
| ff_i | input | 16 | Feed-forward I, signed |
| ff_q | input | 16 | Feed-forward Q, signed |
| kp | input | 16 | Proportional gain, unsigned, 12 fractional bits |
| ki | input | 16 | Integral gain, unsigned, 12 fractional bits |
| integ_lim | input | 16 | Integrator bound magnitude, unsigned |
| out_valid | output | 1 | drive_i/drive_q hold a new sample |
| drive_i | output | 16 | Drive I to the modulator, signed |
| drive_q | output | 16 | Drive Q to the modulator, signed |
| sat_i | output | 1 | I output was saturated on this sample |
| sat_q | output | 1 | Q output was saturated on this sample |

## Verification
The bound check on the integrators compares against the limit that was present on the sample that did the update. It therefore assumes nothing about the limit between samples, and the stimulus changes integ_lim freely, including to values below the current integrator. The hold and valid-latency properties assume every input is a known 0/1 value at each edge after reset. The bench drives every input from reset onward, changes it only at falling edges, and mixes random gaps, enable drops and full-scale values with directed steps for rounding ties, clamping and both saturation rails.

// File: rtl/iqpi_pkg.sv
// Package: shared constants for the I/Q PI regulator.
// Assumes: two channels, I at index 0 and Q at index 1.
package iqpi_pkg;
    localparam int unsigned DEF_DATA_W    = 16;
    localparam int unsigned DEF_GAIN_W    = 16;
    localparam int unsigned DEF_GAIN_FRAC = 12;
    localparam int unsigned NUM_CH        = 2;

    typedef enum int unsigned {
        CH_I = 0,
        CH_Q = 1
    } iq_ch_e;
endpackage

// File: rtl/iqpi_scale.sv
// Module: iqpi_scale
// Multiplies a signed error by an unsigned fixed-point gain and rounds the
// product back to integer units (round half towards plus infinity).
// Assumes: GAIN_FRAC >= 1; purely combinational.
module iqpi_scale #(
    parameter int unsigned ERR_W     = 17,
    parameter int unsigned GAIN_W    = 16,
    parameter int unsigned GAIN_FRAC = 12,
    localparam int unsigned PROD_W   = ERR_W + GAIN_W + 1,
    localparam int unsigned TERM_W   = PROD_W - GAIN_FRAC
) (
    input  logic signed [ERR_W-1:0]  err_i,
    input  logic        [GAIN_W-1:0] gain_i,
    output logic signed [TERM_W-1:0] term_o
);
    localparam logic signed [PROD_W-1:0] HALF_LSB = PROD_W'(1) <<< (GAIN_FRAC - 1);

    logic signed [PROD_W-1:0] err_x;
    logic signed [PROD_W-1:0] gain_x;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] prod_rnd;

    // Extend both operands to the product width, multiply, round and shift.
    always_comb begin
        err_x    = PROD_W'(err_i);
        gain_x   = $signed(PROD_W'({1'b0, gain_i}));
        prod     = err_x * gain_x;
        prod_rnd = (prod + HALF_LSB) >>> GAIN_FRAC;
        term_o   = TERM_W'(prod_rnd);
    end
endmodule

// File: rtl/iqpi_integ.sv
// Module: iqpi_integ
// Integral path of one channel: accumulator with one-sample memory, bounded
// to +/- lim_i after each update and cleared while the loop is off.
// Assumes: inc_i already scaled by the integral gain; lim_i unsigned.
module iqpi_integ #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned INC_W  = 22,
    localparam int unsigned ACC_W = DATA_W + 1,
    localparam int unsigned SUM_W = INC_W + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     loop_en,
    input  logic                     valid_i,
    input  logic signed [INC_W-1:0]  inc_i,
    input  logic        [DATA_W-1:0] lim_i,
    output logic signed [ACC_W-1:0]  acc_next_o
);
    logic signed [ACC_W-1:0] acc_q;
    logic signed [SUM_W-1:0] lim_s;
    logic signed [SUM_W-1:0] raw_sum;
    logic signed [SUM_W-1:0] bounded;

    // Add the increment to the stored value and clamp to the symmetric bound.
    always_comb begin
        lim_s   = $signed(SUM_W'({1'b0, lim_i}));
        raw_sum = SUM_W'(acc_q) + SUM_W'(inc_i);
        if (raw_sum > lim_s) begin
            bounded = lim_s;
        end else if (raw_sum < -lim_s) begin
            bounded = -lim_s;
        end else begin
            bounded = raw_sum;
        end
        acc_next_o = ACC_W'(bounded);
    end

    // Hold the integral between samples; clear it when reset or disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !loop_en) begin
            acc_q <= '0;
        end else if (valid_i) begin
            acc_q <= acc_next_o;
        end
    end

    AST_ACC_IN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && loop_en) |=> (SUM_W'(acc_q) <= $past(lim_s)) && (SUM_W'(acc_q) >= -$past(lim_s))); // R3
    AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_en |=> (acc_q == '0)); // R4
    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_en && !valid_i) |=> $stable(acc_q)); // R2
endmodule

// File: rtl/iqpi_outstage.sv
// Module: iqpi_outstage
// Sums proportional, integral and feed-forward terms, saturates to the data
// width and registers the result with its saturation flag.
// Assumes: terms are sign-extended integers; output updates only on valid_i.
module iqpi_outstage #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned TERM_W = 22,
    localparam int unsigned ACC_W = DATA_W + 1,
    localparam int unsigned SUM_W = TERM_W + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     valid_i,
    input  logic signed [TERM_W-1:0] prop_i,
    input  logic signed [ACC_W-1:0]  integ_i,
    input  logic signed [DATA_W-1:0] ff_i,
    output logic signed [DATA_W-1:0] drive_o,
    output logic                     sat_o
);
    localparam logic signed [SUM_W-1:0] TOP_V = SUM_W'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
    localparam logic signed [SUM_W-1:0] BOT_V = ~TOP_V;

    logic signed [SUM_W-1:0] total;
    logic signed [DATA_W-1:0] clipped;
    logic                     over;

    // Form the full-width sum and clip it to the output range.
    always_comb begin
        total = SUM_W'(prop_i) + SUM_W'(integ_i) + SUM_W'(ff_i);
        over  = 1'b1;
        if (total > TOP_V) begin
            clipped = DATA_W'(TOP_V);
        end else if (total < BOT_V) begin
            clipped = DATA_W'(BOT_V);
        end else begin
            clipped = DATA_W'(total);
            over    = 1'b0;
        end
    end

    // Capture the drive on valid samples; the flag lives for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive_o <= '0;
            sat_o   <= 1'b0;
        end else begin
            sat_o <= valid_i && over;
            if (valid_i) begin
                drive_o <= clipped;
            end
        end
    end

    AST_SAT_AT_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
        sat_o |-> ((drive_o == DATA_W'(TOP_V)) || (drive_o == DATA_W'(BOT_V)))); // R6
    AST_SAT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !sat_o); // R6
    AST_DRIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(drive_o)); // R7
endmodule

// File: rtl/iqpi_channel.sv
// Module: iqpi_channel
// One complete PI loop for a single quadrature component: error, scaled
// proportional and integral terms, accumulator and output stage.
// Assumes: gains share one fixed-point format; no derivative path.
module iqpi_channel #(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned GAIN_W    = 16,
    parameter int unsigned GAIN_FRAC = 12,
    localparam int unsigned ERR_W    = DATA_W + 1,
    localparam int unsigned TERM_W   = ERR_W + GAIN_W + 1 - GAIN_FRAC,
    localparam int unsigned ACC_W    = DATA_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     loop_en,
    input  logic                     valid_i,
    input  logic signed [DATA_W-1:0] meas_i,
    input  logic signed [DATA_W-1:0] setp_i,
    input  logic signed [DATA_W-1:0] ff_i,
    input  logic        [GAIN_W-1:0] kp_i,
    input  logic        [GAIN_W-1:0] ki_i,
    input  logic        [DATA_W-1:0] lim_i,
    output logic signed [DATA_W-1:0] drive_o,
    output logic                     sat_o
);
    logic signed [ERR_W-1:0]  err;
    logic signed [TERM_W-1:0] p_term;
    logic signed [TERM_W-1:0] p_gated;
    logic signed [TERM_W-1:0] i_inc;
    logic signed [ACC_W-1:0]  acc_next;
    logic signed [ACC_W-1:0]  i_gated;

    // Error with one guard bit so full-scale differences do not wrap.
    always_comb begin
        err = ERR_W'(setp_i) - ERR_W'(meas_i);
    end

    iqpi_scale #(
        .ERR_W(ERR_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)
    ) u_prop (
        .err_i(err), .gain_i(kp_i), .term_o(p_term)
    );

    iqpi_scale #(
        .ERR_W(ERR_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)
    ) u_intg_scale (
        .err_i(err), .gain_i(ki_i), .term_o(i_inc)
    );

    iqpi_integ #(
        .DATA_W(DATA_W), .INC_W(TERM_W)
    ) u_integ (
        .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .valid_i(valid_i),
        .inc_i(i_inc), .lim_i(lim_i), .acc_next_o(acc_next)
    );

    // Open-loop operation passes only the feed-forward term.
    always_comb begin
        p_gated = loop_en ? p_term   : '0;
        i_gated = loop_en ? acc_next : '0;
    end

    iqpi_outstage #(
        .DATA_W(DATA_W), .TERM_W(TERM_W)
    ) u_out (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i),
        .prop_i(p_gated), .integ_i(i_gated), .ff_i(ff_i),
        .drive_o(drive_o), .sat_o(sat_o)
    );
endmodule

// File: rtl/iq_pi_ctrl.sv
// Module: iq_pi_ctrl
// Top level: two independent PI channels (I and Q) sharing gains, bound and
// enable, plus the output valid register. One clock from sample to drive.
// Assumes: in_valid may be asserted on any cycle, including back to back.
module iq_pi_ctrl
    import iqpi_pkg::*;
#(
    parameter int unsigned DATA_W    = DEF_DATA_W,
    parameter int unsigned GAIN_W    = DEF_GAIN_W,
    parameter int unsigned GAIN_FRAC = DEF_GAIN_FRAC
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     loop_en,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] meas_i,
    input  logic signed [DATA_W-1:0] meas_q,
    input  logic signed [DATA_W-1:0] setp_i,
    input  logic signed [DATA_W-1:0] setp_q,
    input  logic signed [DATA_W-1:0] ff_i,
    input  logic signed [DATA_W-1:0] ff_q,
    input  logic        [GAIN_W-1:0] kp,
    input  logic        [GAIN_W-1:0] ki,
    input  logic        [DATA_W-1:0] integ_lim,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] drive_i,
    output logic signed [DATA_W-1:0] drive_q,
    output logic                     sat_i,
    output logic                     sat_q
);
    logic [NUM_CH-1:0][DATA_W-1:0] meas_v;
    logic [NUM_CH-1:0][DATA_W-1:0] setp_v;
    logic [NUM_CH-1:0][DATA_W-1:0] ff_v;
    logic [NUM_CH-1:0][DATA_W-1:0] drive_v;
    logic [NUM_CH-1:0]             sat_v;

    // Gather per-channel inputs into indexed vectors.
    always_comb begin
        meas_v[CH_I] = meas_i;
        meas_v[CH_Q] = meas_q;
        setp_v[CH_I] = setp_i;
        setp_v[CH_Q] = setp_q;
        ff_v[CH_I]   = ff_i;
        ff_v[CH_Q]   = ff_q;
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic signed [DATA_W-1:0] drv;
        iqpi_channel #(
            .DATA_W(DATA_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)
        ) u_chan (
            .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .valid_i(in_valid),
            .meas_i($signed(meas_v[ch])), .setp_i($signed(setp_v[ch])),
            .ff_i($signed(ff_v[ch])), .kp_i(kp), .ki_i(ki), .lim_i(integ_lim),
            .drive_o(drv), .sat_o(sat_v[ch])
        );
        assign drive_v[ch] = drv;
    end

    // Spread the channel results onto the named ports.
    always_comb begin
        drive_i = $signed(drive_v[CH_I]);
        drive_q = $signed(drive_v[CH_Q]);
        sat_i   = sat_v[CH_I];
        sat_q   = sat_v[CH_Q];
    end

    // Output valid follows the input valid by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R7
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R7
    AST_FLAGS_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_i || sat_q) |-> out_valid); // R6
endmodule

// File: tb/tb_iq_pi_ctrl.sv
// Bench: directed corner cases followed by seeded random samples, compared
// against a behavioural model of both PI channels.
module tb_iq_pi_ctrl;
    localparam int GF = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic loop_en = 1'b0;
    logic in_valid = 1'b0;
    logic signed [15:0] meas_i = '0, meas_q = '0, setp_i = '0, setp_q = '0, ff_i = '0, ff_q = '0;
    logic [15:0] kp = '0, ki = '0, integ_lim = '0;
    logic out_valid, sat_i, sat_q;
    logic signed [15:0] drive_i, drive_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    longint m_acc_i = 0, m_acc_q = 0, m_out_i = 0, m_out_q = 0;

    always #4 clk = ~clk;

    iq_pi_ctrl dut (
        .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .in_valid(in_valid),
        .meas_i(meas_i), .meas_q(meas_q), .setp_i(setp_i), .setp_q(setp_q),
        .ff_i(ff_i), .ff_q(ff_q), .kp(kp), .ki(ki), .integ_lim(integ_lim),
        .out_valid(out_valid), .drive_i(drive_i), .drive_q(drive_q),
        .sat_i(sat_i), .sat_q(sat_q)
    );

    function automatic longint rshift(longint p);
        return (p + (64'sd1 <<< (GF - 1))) >>> GF;
    endfunction

    function automatic longint sat16(longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Model of one channel for one valid, enabled sample.
    task automatic model_ch(input longint sp, input longint ms, input longint ff,
                            input longint kpv, input longint kiv, input longint lim,
                            inout longint acc, output longint out, output bit sat);
        longint e, p, a, t;
        e = sp - ms;
        p = rshift(e * kpv);
        a = acc + rshift(e * kiv);
        if (a > lim) a = lim;
        if (a < -lim) a = -lim;
        acc = a;
        t = p + a + ff;
        out = sat16(t);
        sat = (t != out);
    endtask

    // Drive one cycle of inputs at a falling edge and check at the next one.
    task automatic step(input string req, input bit v, input bit en,
                        input longint mi, input longint mq, input longint si, input longint sq,
                        input longint fi, input longint fq,
                        input longint kpv, input longint kiv, input longint lim);
        bit e_si, e_sq;
        e_si = 1'b0; e_sq = 1'b0;
        in_valid = v; loop_en = en;
        meas_i = 16'(mi); meas_q = 16'(mq); setp_i = 16'(si); setp_q = 16'(sq);
        ff_i = 16'(fi); ff_q = 16'(fq);
        kp = 16'(kpv); ki = 16'(kiv); integ_lim = 16'(lim);
        if (!en) begin
            m_acc_i = 0; m_acc_q = 0;
            if (v) begin
                m_out_i = fi; m_out_q = fq;
            end
        end else if (v) begin
            model_ch(si, mi, fi, kpv, kiv, lim, m_acc_i, m_out_i, e_si);
            model_ch(sq, mq, fq, kpv, kiv, lim, m_acc_q, m_out_q, e_sq);
        end
        @(negedge clk);
        check({req, " out_valid R7"}, longint'(out_valid), longint'(v));
        check({req, " drive_i"}, longint'(drive_i), m_out_i);
        check({req, " drive_q R8"}, longint'(drive_q), m_out_q);
        check({req, " sat_i R6"}, longint'(sat_i), longint'(e_si));
        check({req, " sat_q R6"}, longint'(sat_q), longint'(e_sq));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240613));
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 out_valid", longint'(out_valid), 0);
        check("R10 drive_i", longint'(drive_i), 0);
        check("R10 drive_q", longint'(drive_q), 0);
        check("R10 sat", longint'(sat_i | sat_q), 0);
        rst_n = 1'b1;

        // R1: proportional only, unity gain, then half gain with rounding ties
        step("R1 unity", 1, 1, 400, -200, 1000, 300, 0, 0, 4096, 0, 1000);
        step("R1 tie", 1, 1, 0, 3, 3, 0, 0, 0, 2048, 0, 1000);
        // R10: integrators still zero after P-only samples -> ki step from zero
        // R2: integrator accumulates 100 per sample
        step("R2 a", 1, 1, 0, 0, 100, -50, 0, 0, 0, 4096, 1000);
        step("R2 b", 1, 1, 0, 0, 100, -50, 0, 0, 0, 4096, 1000);
        step("R2 c", 1, 1, 0, 0, 100, -50, 5, -5, 0, 4096, 1000);
        // R7: idle cycles hold the outputs
        step("R7 idle", 0, 1, 9, 9, 9999, -9999, 7, 7, 4096, 4096, 1000);
        step("R7 idle2", 0, 1, 1, 2, 3, 4, 5, 6, 100, 100, 1000);
        // R3: clamp to a reduced bound, both polarities
        step("R3 pos", 1, 1, 0, 0, 100, -50, 0, 0, 0, 4096, 250);
        step("R3 clamp", 1, 1, 0, 0, 1000, -1000, 0, 0, 0, 4096, 250);
        step("R3 swing", 1, 1, 1000, -1000, 0, 0, 0, 0, 0, 4096, 250);
        // R4: disable clears integrator, output is feed-forward only
        step("R4 off", 1, 0, 500, 500, -500, 900, 77, -33, 4096, 4096, 250);
        step("R4 off idle", 0, 0, 0, 0, 0, 0, 0, 0, 4096, 4096, 250);
        step("R4 restart", 1, 1, 0, 0, 10, 20, 0, 0, 0, 4096, 250);
        // R5/R6: saturation at both rails, flags for one cycle
        step("R5 top", 1, 1, -32768, 32767, 32767, -32768, 0, 0, 65535, 0, 0);
        step("R5 hold", 0, 1, 0, 0, 0, 0, 0, 0, 65535, 0, 0);
        step("R5 ff", 1, 1, 0, 0, 16000, -16000, 20000, -20000, 4096, 0, 0);
        step("R6 clear", 1, 1, 0, 0, 1, -1, 0, 0, 4096, 0, 0);
        // R9: gain change between consecutive samples
        step("R9 g1", 1, 1, 0, 0, 64, 64, 0, 0, 4096, 0, 100);
        step("R9 g2", 1, 1, 0, 0, 64, 64, 0, 0, 1024, 0, 100);
        step("R9 lim", 1, 1, 0, 0, 64, -64, 0, 0, 0, 8192, 30);

        // R8 and all others: seeded random samples
        for (int n = 0; n < 600; n++) begin
            longint lim_r;
            bit v, en;
            v  = ($urandom % 4) != 0;
            en = ($urandom % 12) != 0;
            lim_r = (($urandom % 3) == 0) ? longint'($urandom % 65536) : longint'($urandom % 4000);
            step("RND", v, en,
                 longint'($signed(16'($urandom))), longint'($signed(16'($urandom))),
                 longint'($signed(16'($urandom))), longint'($signed(16'($urandom))),
                 longint'($signed(16'($urandom))) / 4, longint'($signed(16'($urandom))) / 4,
                 longint'($urandom % 8192), longint'($urandom % 2048), lim_r);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule